// File: doc/BRIEF.md
# Systolic Insertion Sorter

This block sorts one batch of up to `NUM_CELLS` keys while they stream in. It is a chain of identical cells, each holding one key register that is preset to the largest code the key width can carry, which stands for an empty slot. A key that enters at the left end meets each cell in turn. The cell keeps whichever of the two keys is smaller and sends the other one, one cycle later, to the cell on its right. Because of this the sorting work overlaps the loading: once the last key is in, the array only has to wait for the keys still moving through the chain to come to rest.

A batch starts with a one-cycle clear. Keys are then offered one per cycle with a valid strobe, and the final key is flagged. Loading also closes by itself once the chain is full. When no key is still moving, the cells shift toward the left end one position per cycle. The left end presents the keys smallest first with an output valid, and exactly as many keys come out as went in. A done flag then rises and stays high until the next clear.

Top module: `sys_insert_sorter`

## Requirements
- R1: After reset, out_vld_o and done_o are both low.
- R2: clr_i empties every cell to the all-ones key and restarts a batch. In the cycle after a clear, out_vld_o and done_o are both low, and no key from an earlier batch appears in later output.
- R3: A cell that receives a valid key keeps the strictly smaller of the incoming and stored keys. It sends the other key to its right neighbour one cycle later, and a cell with no valid input holds its key.
- R4: The output stream lists the accepted keys in nondescending order, one per cycle with out_vld_o high, and carries exactly as many keys as were accepted.
- R5: Duplicate keys are all kept, and each copy appears in the output.
- R6: Keys equal to the all-ones code (255 at the default width) are sorted and output like any other key.
- R7: Suppose the final key of a batch is accepted at clock edge E. Then out_vld_o first rises after edge E+NUM_CELLS, which leaves NUM_CELLS-1 cycles for the keys still moving to come to rest.
- R8: vld_i is ignored outside the loading phase, and this includes the output phase. Loading ends by itself after NUM_CELLS keys, and any later keys are dropped.
- R9: done_o rises in the cycle after the last output key, is never high together with out_vld_o, and stays high until clr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Start of batch: empties the cells and starts loading |
| vld_i | input | 1 | Input key valid |
| last_i | input | 1 | Marks the final key of the batch when vld_i is high |
| key_i | input | KEY_W | Input key |
| out_vld_o | output | 1 | Output key valid |
| out_key_o | output | KEY_W | Output key, smallest first |
| done_o | output | 1 | Batch fully output, held until clr_i |

## Verification
The bench uses duplicate keys and batches made entirely of the all-ones code. A design that drops one of two equal keys, or that confuses a real all-ones key with an empty slot, would then output too few keys or the wrong ones. It checks that output starts in exactly the cycle the settle rule requires. Draining too early loses keys that are still moving into the last cell, and draining late breaks the cycle count. It also aborts a drain with a clear, so that leftover small keys would appear in the next batch if the cells were not emptied. It sends keys during the drain and past a full chain, so that a design that accepts them would corrupt or lengthen the output.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_SETTLE,
    S_DRAIN,
    S_DONE
  } sort_state_e;
endpackage

// File: rtl/sort_cell.sv
module sort_cell #(
  parameter int KEY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             in_vld_i,
  input  logic [KEY_W-1:0] in_key_i,
  input  logic [KEY_W-1:0] right_key_i,
  output logic [KEY_W-1:0] key_o,
  output logic             fwd_vld_o,
  output logic [KEY_W-1:0] fwd_key_o
);
  localparam logic [KEY_W-1:0] KEY_MAX = '1;

  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q     <= KEY_MAX;
      fwd_vld_o <= 1'b0;
      fwd_key_o <= '0;
    end else if (clr_i) begin
      key_q     <= KEY_MAX;
      fwd_vld_o <= 1'b0;
    end else if (shift_i) begin
      key_q     <= right_key_i;
      fwd_vld_o <= 1'b0;
    end else if (in_vld_i) begin
      fwd_vld_o <= 1'b1;
      // ties pass the newcomer on: earlier equal key stays left
      if (in_key_i < key_q) begin
        key_q     <= in_key_i;
        fwd_key_o <= key_q;
      end else begin
        fwd_key_o <= in_key_i;
      end
    end else begin
      fwd_vld_o <= 1'b0;
    end
  end

  assign key_o = key_q;

  a_r2_clear_to_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (key_o == KEY_MAX && !fwd_vld_o));

  a_r3_fwd_not_smaller: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_vld_o |-> (fwd_key_o >= key_o));

  a_r3_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !shift_i && !in_vld_i) |=> $stable(key_o));
endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl
  import sorter_pkg::*;
#(
  parameter int NUM_CELLS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic vld_i,
  input  logic last_i,
  input  logic busy_i,
  output logic accept_o,
  output logic shift_o,
  output logic out_vld_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(NUM_CELLS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL_M1 = CNT_W'(NUM_CELLS - 1);

  sort_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else if (clr_i) begin
      state_q <= S_LOAD;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        S_LOAD: if (vld_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (last_i || cnt_q == CNT_FULL_M1) state_q <= S_SETTLE;
        end
        S_SETTLE: if (!busy_i) state_q <= S_DRAIN;
        S_DRAIN: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= S_DONE;
        end
        default: ;
      endcase
    end
  end

  assign accept_o  = (state_q == S_LOAD) && vld_i && !clr_i;
  assign shift_o   = (state_q == S_DRAIN) && !clr_i;
  assign out_vld_o = (state_q == S_DRAIN);
  assign done_o    = (state_q == S_DONE);

  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NUM_CELLS));

  a_r9_not_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_vld_o && done_o));

  a_r8_no_accept_in_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> !accept_o);
endmodule

// File: rtl/sys_insert_sorter.sv
module sys_insert_sorter #(
  parameter int NUM_CELLS = 8,
  parameter int KEY_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             vld_i,
  input  logic             last_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             out_vld_o,
  output logic [KEY_W-1:0] out_key_o,
  output logic             done_o
);
  localparam logic [KEY_W-1:0] KEY_MAX = '1;

  logic [KEY_W-1:0] cell_key  [NUM_CELLS];
  logic [KEY_W-1:0] chain_key [NUM_CELLS+1];
  logic [NUM_CELLS:0] chain_vld;
  logic accept, shift, busy;

  assign chain_vld[0] = accept;
  assign chain_key[0] = key_i;
  // cells 0..N-2 forwarding means a key is still moving
  assign busy = |chain_vld[NUM_CELLS-1:1];

  sort_ctrl #(.NUM_CELLS(NUM_CELLS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .vld_i    (vld_i),
    .last_i   (last_i),
    .busy_i   (busy),
    .accept_o (accept),
    .shift_o  (shift),
    .out_vld_o(out_vld_o),
    .done_o   (done_o)
  );

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    logic [KEY_W-1:0] right_key;
    if (i == NUM_CELLS - 1) begin : g_tail
      assign right_key = KEY_MAX;
    end else begin : g_body
      assign right_key = cell_key[i+1];
    end
    sort_cell #(.KEY_W(KEY_W)) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr_i),
      .shift_i    (shift),
      .in_vld_i   (chain_vld[i]),
      .in_key_i   (chain_key[i]),
      .right_key_i(right_key),
      .key_o      (cell_key[i]),
      .fwd_vld_o  (chain_vld[i+1]),
      .fwd_key_o  (chain_key[i+1])
    );
  end

  assign out_key_o = cell_key[0];

  a_r4_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_o && $past(out_vld_o)) |-> (out_key_o >= $past(out_key_o)));

  a_r9_done_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(out_vld_o) && !$past(clr_i)) |-> done_o);

  a_r3_tail_drop_ge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_vld[NUM_CELLS] |-> (chain_key[NUM_CELLS] >= cell_key[NUM_CELLS-1]));

  a_r7_no_drain_while_moving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_o && !$past(out_vld_o)) |-> !$past(busy));
endmodule

// File: tb/sim_sys_insert_sorter.sv
module sim_sys_insert_sorter;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 8;
  localparam int KW = 8;
  localparam int NV = 7;

  localparam logic [KW-1:0] VEC_KEYS [NV][P] = '{
    '{8'd9,   8'd3,  8'd7,   8'd1,  8'd8,  8'd2,  8'd6,   8'd4},
    '{8'd80,  8'd70, 8'd60,  8'd50, 8'd40, 8'd30, 8'd20,  8'd10},
    '{8'd1,   8'd2,  8'd3,   8'd4,  8'd5,  8'd6,  8'd7,   8'd8},
    '{8'd5,   8'd5,  8'd2,   8'd5,  8'd2,  8'd0,  8'd0,   8'd0},
    '{8'd255, 8'd255,8'd255, 8'd255,8'd255,8'd0,  8'd0,   8'd0},
    '{8'd42,  8'd0,  8'd0,   8'd0,  8'd0,  8'd0,  8'd0,   8'd0},
    '{8'd255, 8'd0,  8'd255, 8'd17, 8'd0,  8'd17, 8'd128, 8'd255}
  };
  localparam int VEC_N [NV] = '{8, 8, 8, 5, 5, 1, 8};

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr = 1'b0, vld = 1'b0, last = 1'b0;
  logic [KW-1:0] key = '0;
  logic out_vld, done;
  logic [KW-1:0] out_key;

  int n_chk = 0, n_fail = 0;
  int stim [P+4];
  int expv [P];

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_insert_sorter #(.NUM_CELLS(P), .KEY_W(KW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .vld_i(vld), .last_i(last),
    .key_i(key), .out_vld_o(out_vld), .out_key_o(out_key), .done_o(done)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic make_expect(input int n);
    for (int i = 0; i < n; i++) expv[i] = stim[i];
    for (int i = 1; i < n; i++)
      for (int j = i; j > 0 && expv[j-1] > expv[j]; j--) begin
        int t = expv[j]; expv[j] = expv[j-1]; expv[j-1] = t;
      end
  endtask

  // n keys sorted, extra keys sent afterwards, poke = vld during drain
  task automatic run_batch(input int n, input int extra, input logic use_last,
                           input logic poke, input string tag);
    int c = 0;
    make_expect(n);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    check(!out_vld && !done, {tag, " R2 idle after clear"}, {out_vld, done}, 0);
    for (int i = 0; i < n + extra; i++) begin
      vld = 1'b1; key = KW'(stim[i]); last = use_last && (i == n - 1);
      @(negedge clk);
      if (i >= n - 1) c++;
    end
    vld = 1'b0; last = 1'b0;
    while (!out_vld && c < P + 6) begin
      @(negedge clk); c++;
    end
    check(c == P + 1, {tag, " R7 drain start cycle"}, c, P + 1);
    for (int k = 0; k < n; k++) begin
      if (poke) begin vld = 1'b1; key = KW'(k); end
      check(out_vld && out_key == KW'(expv[k]), {tag, " R4 sorted key"},
            out_vld ? int'(out_key) : -1, expv[k]);
      @(negedge clk);
    end
    vld = 1'b0;
    check(!out_vld && done, {tag, " R9 done after last key / R4 count"}, {out_vld, done}, 1);
    @(negedge clk);
    check(done && !out_vld, {tag, " R9 done held"}, {out_vld, done}, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    check(!out_vld && !done, "R1 reset outputs", {out_vld, done}, 0);
    rst_n = 1'b1;
    // vld before any clear must be ignored (R8)
    @(negedge clk) begin vld = 1'b1; key = 8'd3; end
    @(negedge clk) vld = 1'b0;
    check(!out_vld && !done, "R8 idle vld ignored", {out_vld, done}, 0);

    // R3 R5 R6 table walk
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < P; i++) stim[i] = VEC_KEYS[v][i];
      run_batch(VEC_N[v], 0, 1'b1, v[0], $sformatf("vec%0d R3 R5 R6", v));
    end

    // random batches with duplicates and max keys
    for (int b = 0; b < 12; b++) begin
      int n = 1 + ($urandom % P);
      for (int i = 0; i < n; i++) begin
        int r = $urandom % 10;
        stim[i] = (r == 0) ? 255 : (r == 1) ? 7 : int'($urandom % 256);
      end
      run_batch(n, 0, 1'b1, b[0], $sformatf("rnd%0d R5", b));
    end

    // R8 auto end when full; extra keys dropped
    for (int i = 0; i < P + 3; i++) stim[i] = (i < P) ? 100 + i : 1;
    run_batch(P, 3, 1'b0, 1'b1, "full R8");

    // R2 clear mid-drain, then a new batch must not see old keys
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      vld = 1'b1; key = KW'(i + 1); last = (i == 2);
      @(negedge clk);
    end
    vld = 1'b0; last = 1'b0;
    while (!out_vld) @(negedge clk);
    check(out_key == 8'd1, "R4 first of aborted batch", out_key, 1);
    clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    check(!out_vld && !done, "R2 abort by clear", {out_vld, done}, 0);
    stim[0] = 200; stim[1] = 100;
    run_batch(2, 0, 1'b1, 1'b0, "after abort R2");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule